// File: doc/BRIEF.md
# Protected Main Clock Source Select Register

This block holds the selection code that tells a downstream clock switcher which of three oscillators should drive the main system clock: the calibrated fast internal oscillator, the slow internal oscillator, or an external clock. The code lives in an 8-bit memory-mapped register. Software can rewrite it at run time to move the system to another clock source.

Because a stray write could stop or slow the whole chip, the select field is guarded. Software first writes a fixed signature byte to a separate change-protection register. That write opens a short unlock window, and the window is measured in cycle-enable pulses that stand in for instruction cycles. Only a select write that lands while the window is open can change the selection. Any other select write is dropped without notice. The protection register reads back whether the window is currently open.

Top module: `clksel_guard`

## Requirements
- R1: After reset, and again after any later reset, `clk_sel` is 00 (fast internal oscillator), the select register reads 0x00 and the protection register reads 0x00 (window closed).
- R2: A read at the select address (default 0x6) returns the current code in bits 1:0 and zeros in bits 7:2. `clk_sel` always equals that code, and bits 7:2 of written data are discarded.
- R3: Writing 0xD8 to the protection address (default 0xC) opens the window on the next cycle. While the window is open the protection register reads 0x01; while it is closed it reads 0x00.
- R4: Writing any value other than 0xD8 to the protection address does not open the window, and a select write that follows it is ignored.
- R5: A select write with code 00, 01 or 10 while the window is open changes `clk_sel` to that code on the next cycle and closes the window. A second select write after it is ignored.
- R6: A select write while the window is closed leaves `clk_sel` unchanged.
- R7: The window stays open through three `tick` pulses and closes on the fourth. A select write in the same cycle as the fourth pulse is still accepted, and one after it is ignored.
- R8: A write of the reserved code 11 is ignored even inside the window. The previous code is kept and the window stays open for a later valid write.
- R9: Writing 0xD8 again while the window is open restarts the count at four pulses.
- R10: Reads at any other address return 0x00. Writes there change neither `clk_sel` nor the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Cycle-enable pulse that ages the unlock window |
| rd_data | output | 8 | Read data for `addr` (combinational by default) |
| clk_sel | output | 2 | Main clock source code driven to the switcher |

## Verification
The hardest situations to reach are at the edges of the window: a select write in the exact cycle of the fourth tick, a select write one pulse later, and a signature rewrite that restarts an almost expired window. The stimulus builds these as exact sequences of tick-only cycles after the signature write, and it places the tick on the same cycle as the write when the case calls for it. Both sides of each edge are then checked by reading the protection and select registers. A reserved-code write inside the window is followed by a read of the protection register, which shows the window stayed open, and then by a valid write, which shows the window can still be used.

// File: rtl/clksel_guard_pkg.sv
package clksel_guard_pkg;

   typedef enum logic [1:0] {
      SRC_FAST_INT = 2'b00,
      SRC_SLOW_INT = 2'b01,
      SRC_EXT      = 2'b10,
      SRC_RSVD     = 2'b11
   } clk_src_e;

   typedef struct packed {
      logic wr_sel;
      logic wr_key;
      logic rd_sel;
      logic rd_key;
   } bus_hit_t;

endpackage

// File: rtl/clksel_addr_dec.sv
module clksel_addr_dec
   import clksel_guard_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 4'h6,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 4'hC
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   output bus_hit_t          hit
);
   logic is_sel;
   logic is_key;

   assign is_sel = (addr == SEL_ADDR);
   assign is_key = (addr == KEY_ADDR);

   always_comb begin
      hit.wr_sel = wr_en & is_sel;
      hit.wr_key = wr_en & is_key;
      hit.rd_sel = is_sel;
      hit.rd_key = is_key;
   end
endmodule

// File: rtl/clksel_unlock_win.sv
module clksel_unlock_win #(
   parameter int DATA_W = 8,
   parameter int WIN_CYC = 4,
   parameter logic [DATA_W-1:0] KEY = 8'hD8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick,
   input  logic              accept,
   output logic              win_open
);
   localparam int CNT_W = $clog2(WIN_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(WIN_CYC);

   logic [CNT_W-1:0] left_q;
   logic             key_ok;

   assign key_ok = key_wr && (wr_data == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (key_ok)
         left_q <= LOAD;
      else if (accept)
         left_q <= '0;
      else if (tick && (left_q != '0))
         left_q <= left_q - 1'b1;
   end

   assign win_open = (left_q != '0);
endmodule

// File: rtl/clksel_sel_reg.sv
module clksel_sel_reg #(
   parameter int SEL_W = 2,
   parameter int NUM_SRC = 3,
   parameter int RST_SRC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic             win_open,
   input  logic [SEL_W-1:0] code,
   output logic             accept,
   output logic [SEL_W-1:0] sel
);
   localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NUM_SRC);
   localparam logic [SEL_W-1:0] RST_VAL = SEL_W'(RST_SRC);

   logic legal;

   generate
      if (NUM_SRC == (1 << SEL_W)) begin : g_all_legal
         assign legal = 1'b1;
      end else begin : g_range_check
         assign legal = ({1'b0, code} < LIMIT);
      end
   endgenerate

   assign accept = wr_sel && win_open && legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel <= RST_VAL;
      else if (accept)
         sel <= code;
   end
endmodule

// File: rtl/clksel_guard.sv
module clksel_guard
   import clksel_guard_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int SEL_W = 2,
   parameter int NUM_SRC = 3,
   parameter int WIN_CYC = 4,
   parameter int RST_SRC = int'(SRC_FAST_INT),
   parameter logic [ADDR_W-1:0] SEL_ADDR = 4'h6,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 4'hC,
   parameter logic [DATA_W-1:0] KEY = 8'hD8,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick,
   output logic [DATA_W-1:0] rd_data,
   output logic [SEL_W-1:0]  clk_sel
);
   generate
      if (SEL_W < 1 || SEL_W > DATA_W) begin : g_bad_w
         $error("SEL_W must lie in 1..DATA_W");
      end
      if (NUM_SRC < 1 || NUM_SRC > (1 << SEL_W)) begin : g_bad_n
         $error("NUM_SRC does not fit in SEL_W bits");
      end
      if (RST_SRC >= NUM_SRC) begin : g_bad_rst
         $error("RST_SRC must be a legal source code");
      end
      if (WIN_CYC < 1) begin : g_bad_win
         $error("WIN_CYC must be at least 1");
      end
      if (SEL_ADDR == KEY_ADDR) begin : g_bad_addr
         $error("SEL_ADDR and KEY_ADDR must differ");
      end
   endgenerate

   bus_hit_t          hit;
   logic              win_open;
   logic              accept;
   logic [SEL_W-1:0]  sel;
   logic [DATA_W-1:0] rd_next;

   clksel_addr_dec #(
      .ADDR_W   (ADDR_W),
      .SEL_ADDR (SEL_ADDR),
      .KEY_ADDR (KEY_ADDR)
   ) u_dec (
      .addr  (addr),
      .wr_en (wr_en),
      .hit   (hit)
   );

   clksel_unlock_win #(
      .DATA_W  (DATA_W),
      .WIN_CYC (WIN_CYC),
      .KEY     (KEY)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (hit.wr_key),
      .wr_data  (wr_data),
      .tick     (tick),
      .accept   (accept),
      .win_open (win_open)
   );

   clksel_sel_reg #(
      .SEL_W   (SEL_W),
      .NUM_SRC (NUM_SRC),
      .RST_SRC (RST_SRC)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (hit.wr_sel),
      .win_open (win_open),
      .code     (wr_data[SEL_W-1:0]),
      .accept   (accept),
      .sel      (sel)
   );

   always_comb begin
      rd_next = '0;
      if (hit.rd_sel)
         rd_next[SEL_W-1:0] = sel;
      else if (hit.rd_key)
         rd_next[0] = win_open;
   end

   generate
      if (RD_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rd_data <= '0;
            else
               rd_data <= rd_next;
         end
      end else begin : g_rd_comb
         assign rd_data = rd_next;
      end
   endgenerate

   assign clk_sel = sel;
endmodule

// File: rtl/clksel_guard_chk.sv
module clksel_guard_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int SEL_W = 2,
   parameter int NUM_SRC = 3,
   parameter int WIN_CYC = 4,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 4'h6,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 4'hC,
   parameter logic [DATA_W-1:0] KEY = 8'hD8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              tick,
   input logic [DATA_W-1:0] rd_data,
   input logic [SEL_W-1:0]  clk_sel,
   input logic              win_open
);
   localparam int CK_W = $clog2(WIN_CYC + 1) + 1;
   localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NUM_SRC);

   logic            sel_try;
   logic            key_hit;
   logic [CK_W-1:0] ticks_seen;

   assign sel_try = wr_en && (addr == SEL_ADDR) && win_open &&
                    ({1'b0, wr_data[SEL_W-1:0]} < LIMIT);
   assign key_hit = wr_en && (addr == KEY_ADDR) && (wr_data == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ticks_seen <= '0;
      else if (key_hit)
         ticks_seen <= '0;
      else if (tick && win_open && (ticks_seen < CK_W'(WIN_CYC)))
         ticks_seen <= ticks_seen + 1'b1;
   end

   p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:SEL_W] == '0);

   p_key_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> win_open);

   p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_open && !key_hit) |=> !win_open);

   p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_try |=> (clk_sel == $past(wr_data[SEL_W-1:0])) && !win_open);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_try |=> $stable(clk_sel));

   p_window_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ticks_seen >= CK_W'(WIN_CYC)) |-> !win_open);

   p_legal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, clk_sel} < LIMIT);
endmodule

bind clksel_guard clksel_guard_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .SEL_W    (SEL_W),
   .NUM_SRC  (NUM_SRC),
   .WIN_CYC  (WIN_CYC),
   .SEL_ADDR (SEL_ADDR),
   .KEY_ADDR (KEY_ADDR),
   .KEY      (KEY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .tick     (tick),
   .rd_data  (rd_data),
   .clk_sel  (clk_sel),
   .win_open (win_open)
);

// File: tb/tb_clksel_guard.sv
`timescale 1ns/1ps
module tb_clksel_guard;
   localparam logic [3:0] A_SEL = 4'h6;
   localparam logic [3:0] A_KEY = 4'hC;
   localparam logic [3:0] A_OTH = 4'h3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tick = 1'b0;
   logic [7:0] rd_data;
   logic [1:0] clk_sel;

   typedef struct {
      logic [7:0] exp_rd;
      logic [1:0] exp_sel;
      string      req;
   } item_t;

   item_t sb[$];
   logic  strobe = 1'b0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   clksel_guard dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .tick(tick), .rd_data(rd_data), .clk_sel(clk_sel)
   );

   always @(negedge clk) begin
      if (strobe && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         n_chk++;
         if (rd_data !== it.exp_rd || clk_sel !== it.exp_sel) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h clk_sel=%b expected rd_data=%h clk_sel=%b",
                     it.req, rd_data, clk_sel, it.exp_rd, it.exp_sel);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic tk);
      addr = a; wr_data = d; wr_en = 1'b1; tick = tk;
      @(posedge clk); #1;
      wr_en = 1'b0; tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(posedge clk); #1;
      end
      tick = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e,
                     input logic [1:0] s, input string req);
      item_t it;
      it.exp_rd = e; it.exp_sel = s; it.req = req;
      sb.push_back(it);
      addr = a; wr_en = 1'b0; strobe = 1'b1;
      @(posedge clk); #1;
      strobe = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      rd(A_SEL, 8'h00, 2'b00, "R1");
      rd(A_KEY, 8'h00, 2'b00, "R1");
      // R6: closed window
      wr(A_SEL, 8'h01, 1'b0);
      rd(A_SEL, 8'h00, 2'b00, "R6");
      // R4: wrong signature
      wr(A_KEY, 8'h5A, 1'b0);
      rd(A_KEY, 8'h00, 2'b00, "R4");
      wr(A_SEL, 8'h01, 1'b0);
      rd(A_SEL, 8'h00, 2'b00, "R4");
      // R3, R5, R2
      wr(A_KEY, 8'hD8, 1'b0);
      rd(A_KEY, 8'h01, 2'b00, "R3");
      wr(A_SEL, 8'hFD, 1'b0);
      rd(A_SEL, 8'h01, 2'b01, "R2");
      rd(A_KEY, 8'h00, 2'b01, "R5");
      wr(A_SEL, 8'h02, 1'b0);
      rd(A_SEL, 8'h01, 2'b01, "R5");
      // R7: three ticks keep it open
      wr(A_KEY, 8'hD8, 1'b0);
      ticks(3);
      rd(A_KEY, 8'h01, 2'b01, "R7");
      wr(A_SEL, 8'h02, 1'b0);
      rd(A_SEL, 8'h02, 2'b10, "R7");
      // R7: write on the fourth tick is accepted
      wr(A_KEY, 8'hD8, 1'b0);
      ticks(3);
      wr(A_SEL, 8'h00, 1'b1);
      rd(A_SEL, 8'h00, 2'b00, "R7");
      // R7: four ticks close it
      wr(A_KEY, 8'hD8, 1'b0);
      ticks(4);
      rd(A_KEY, 8'h00, 2'b00, "R7");
      wr(A_SEL, 8'h02, 1'b0);
      rd(A_SEL, 8'h00, 2'b00, "R7");
      // R8: reserved code
      wr(A_KEY, 8'hD8, 1'b0);
      wr(A_SEL, 8'h03, 1'b0);
      rd(A_SEL, 8'h00, 2'b00, "R8");
      rd(A_KEY, 8'h01, 2'b00, "R8");
      wr(A_SEL, 8'h02, 1'b0);
      rd(A_SEL, 8'h02, 2'b10, "R8");
      // R9: reload
      wr(A_KEY, 8'hD8, 1'b0);
      ticks(3);
      wr(A_KEY, 8'hD8, 1'b0);
      ticks(3);
      rd(A_KEY, 8'h01, 2'b10, "R9");
      wr(A_SEL, 8'h01, 1'b0);
      rd(A_SEL, 8'h01, 2'b01, "R9");
      // R10: other address
      wr(A_OTH, 8'hD8, 1'b0);
      rd(A_OTH, 8'h00, 2'b01, "R10");
      rd(A_KEY, 8'h00, 2'b01, "R10");
      wr(A_KEY, 8'hD8, 1'b0);
      wr(A_OTH, 8'h02, 1'b0);
      rd(A_SEL, 8'h01, 2'b01, "R10");
      rd(A_KEY, 8'h01, 2'b01, "R10");
      // R1: reset with window open
      #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      @(posedge clk); #1;
      rd(A_SEL, 8'h00, 2'b00, "R1");
      rd(A_KEY, 8'h00, 2'b00, "R1");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule